// File: doc/BRIEF.md
# Biphase Infrared Remote Frame Receiver

This block turns the logic-level output of a demodulating infrared receiver into decoded remote-control key frames. The receiver output rests high and carries a 14-cell biphase frame. In each cell the bit value shows in the first half and its complement in the second half. The block synchronises the line and starts a tick-driven timer on the first falling edge. It then takes one sample a quarter of a cell into each following cell. After each sample it waits for the edge that every cell has at its midpoint. That edge gives a fresh measurement of the cell length and restarts the timer. If the midpoint edge is missing, the frame is treated as cut short and is dropped.

A finished frame produces a 7-bit command, a 5-bit address and the toggle bit, along with a one-cycle valid pulse. A flag tells whether the frame is a fresh key press or a held-key repeat; it is found by comparing the toggle bit with the toggle value kept from the previous frame. A dropped frame produces a one-cycle error pulse instead. The timer advances on a tick enable that the surrounding chip supplies every microsecond, so the default nominal cell length is 1778 ticks.

Top module: `ir_biphase_rx`

## Requirements
- R1: The block starts a frame only on a falling edge of the synchronised line, and only after it has seen that line high. This holds after reset and after every completed or dropped frame, so a line that is low out of reset or after a dropped frame does not start a frame until it has gone high and then fallen.
- R2: Each cell length estimate starts at NOM_TICKS when a frame starts. A sample is taken once the timer reaches three quarters of the current estimate. The timer counts only on cycles with tick_en high.
- R3: Only an edge in either direction that arrives after a sample counts as a midpoint edge. It loads the timer value as the new cell estimate and restarts the timer. Edges at cell boundaries, which come before the sample point, are ignored. Frames whose cell length differs from nominal by about ±20 % are therefore decoded.
- R4: If no midpoint edge arrives by five quarters of the current estimate after the last restart, the frame is dropped. err_o pulses for one cycle, valid_o stays low and all field outputs keep their previous values. With NOM_TICKS=40, a first cell of 48 ticks decodes and a first cell of 52 ticks is dropped.
- R5: Fourteen samples are taken and the last is discarded. In arrival order the samples are: the second start bit, the toggle bit, address bits 4 down to 0, then command bits 5 down to 0. cmd_o[6] is the inverse of the second start bit.
- R6: valid_o is high for exactly one cycle per decoded frame. cmd_o, addr_o, toggle_o and is_new_o change only in that cycle and otherwise hold their values.
- R7: is_new_o is 1 on the first decoded frame after reset. After that it is 1 exactly when the frame's toggle bit differs from the toggle bit of the previous decoded frame, and 0 for a repeat.
- R8: The line edges that follow a frame's last cell give no extra frame start, no error and no second valid pulse.
- R9: While rst is high and right after it, valid_o, err_o, is_new_o, toggle_o, cmd_o and addr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer advance enable, nominally once per microsecond |
| ir_line | input | 1 | Receiver output, idles high, asynchronous to clk |
| cmd_o | output | 7 | Decoded command, bit 6 from the inverted second start bit |
| addr_o | output | 5 | Decoded address |
| toggle_o | output | 1 | Toggle bit of the last decoded frame |
| valid_o | output | 1 | One-cycle pulse when a frame has been decoded |
| is_new_o | output | 1 | 1 for a new key press, 0 for a repeat |
| err_o | output | 1 | One-cycle pulse when a truncated frame is dropped |

## Verification
The bench builds the receiver with NOM_TICKS=40 and tick_en held high, so one cell lasts 40 clocks. A whole frame and its idle gap then take under a thousand cycles. This scaling brings both sides of the first-cell timeout within reach: cells of 36, 44 and 48 ticks decode, and a 52-tick first cell is dropped. It also makes it quick to run toggle sequences of repeats and fresh presses, to truncate frames with the line left high or held low, and to check re-arming after a low line.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    // Number of cells in one biphase frame (protocol constant)
    localparam int FRAME_BITS = 14;

    typedef enum logic [2:0] {
        ST_ARM,     // wait for the line to be high
        ST_IDLE,    // armed, wait for the starting falling edge
        ST_SAMPLE,  // wait for the quarter-cell sample point
        ST_EDGE,    // wait for the mid-cell edge or time out
        ST_DONE     // all samples taken
    } rx_state_e;

    typedef struct packed {
        logic [6:0] cmd;
        logic [4:0] addr;
        logic       tog;
    } ir_frame_t;

    // Samples enter at bit 0 and move up: bit 13 holds the second start
    // bit, bit 0 the discarded trailing sample.
    function automatic ir_frame_t unpack_frame(input logic [FRAME_BITS-1:0] sh);
        ir_frame_t f;
        f.cmd  = {~sh[13], sh[6:1]};
        f.tog  = sh[12];
        f.addr = sh[11:7];
        return f;
    endfunction

endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic fall_o,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Reset to low so a high line out of reset looks like a rise, not a fall
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level_o = sync_q[SYNC_STAGES-1];
    assign fall_o  = prev_q & ~level_o;
    assign edge_o  = prev_q ^ level_o;

endmodule

// File: rtl/ir_cell_timer.sv
module ir_cell_timer #(
    parameter int NOM_TICKS = 1778,
    parameter int W         = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic load_nom_i,
    input  logic capture_i,
    output logic at_sample_o,
    output logic at_timeout_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] per_q;
    logic [W:0]   samp_pt;
    logic [W:0]   tmo_pt;
    logic         restart;

    assign restart = load_nom_i | capture_i;

    // three quarters and five quarters of the current estimate
    assign samp_pt = {1'b0, per_q >> 1} + {1'b0, per_q >> 2};
    assign tmo_pt  = {1'b0, per_q} + {1'b0, per_q >> 2};

    assign at_sample_o  = {1'b0, cnt_q} >= samp_pt;
    assign at_timeout_o = {1'b0, cnt_q} >= tmo_pt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            per_q <= W'(NOM_TICKS);
        end else begin
            if (restart)
                cnt_q <= '0;
            else if (tick_i && !(&cnt_q))
                cnt_q <= cnt_q + 1'b1;

            if (load_nom_i)
                per_q <= W'(NOM_TICKS);
            else if (capture_i)
                per_q <= (&cnt_q) ? cnt_q : cnt_q + 1'b1;
        end
    end

    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));

    assert_start_nominal_R2: assert property (@(posedge clk) disable iff (rst)
        load_nom_i |=> (per_q == W'(NOM_TICKS)));

    assert_counts_ticks_only_R2: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ir_frame_ctrl.sv
module ir_frame_ctrl
    import ir_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  level_i,
    input  logic                  fall_i,
    input  logic                  edge_i,
    input  logic                  at_sample_i,
    input  logic                  at_timeout_i,
    output logic                  load_nom_o,
    output logic                  capture_o,
    output logic                  done_o,
    output logic                  abort_o,
    output logic [FRAME_BITS-1:0] shreg_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    rx_state_e             state_q, state_d;
    logic [CNT_W-1:0]      nsamp_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic                  take;
    logic                  last;

    assign take = (state_q == ST_SAMPLE) && at_sample_i;
    assign last = (nsamp_q == CNT_W'(FRAME_BITS - 1));

    always_comb begin
        state_d    = state_q;
        load_nom_o = 1'b0;
        capture_o  = 1'b0;
        abort_o    = 1'b0;
        unique case (state_q)
            ST_ARM:    if (level_i) state_d = ST_IDLE;
            ST_IDLE: begin
                if (fall_i) begin
                    load_nom_o = 1'b1;
                    state_d    = ST_SAMPLE;
                end
            end
            ST_SAMPLE: if (take) state_d = last ? ST_DONE : ST_EDGE;
            ST_EDGE: begin
                if (edge_i) begin
                    capture_o = 1'b1;
                    state_d   = ST_SAMPLE;
                end else if (at_timeout_i) begin
                    abort_o = 1'b1;
                    state_d = ST_ARM;
                end
            end
            ST_DONE:   state_d = ST_ARM;
            default:   state_d = ST_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARM;
            nsamp_q <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            if (load_nom_o) begin
                nsamp_q <= '0;
            end else if (take) begin
                nsamp_q <= nsamp_q + 1'b1;
                sh_q    <= {sh_q[FRAME_BITS-2:0], level_i};
            end
        end
    end

    assign done_o  = (state_q == ST_DONE);
    assign shreg_o = sh_q;

    assert_armed_needs_high_R1: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && !level_i) |-> fall_i);

    assert_full_sample_count_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (nsamp_q == CNT_W'(FRAME_BITS)));

    assert_no_sample_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        nsamp_q <= CNT_W'(FRAME_BITS));

endmodule

// File: rtl/ir_biphase_rx.sv
module ir_biphase_rx
    import ir_rx_pkg::*;
#(
    parameter int NOM_TICKS   = 1778,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       ir_line,
    output logic [6:0] cmd_o,
    output logic [4:0] addr_o,
    output logic       toggle_o,
    output logic       valid_o,
    output logic       is_new_o,
    output logic       err_o
);
    localparam int TIMER_W = $clog2(NOM_TICKS) + 2;

    logic                  level, fall, any_edge;
    logic                  at_sample, at_timeout;
    logic                  load_nom, capture, done, abort;
    logic [FRAME_BITS-1:0] shreg;
    ir_frame_t             decoded, frame_q;
    logic                  valid_q, err_q, new_q, stored_q, seen_q;

    ir_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .line_i(ir_line),
        .level_o(level), .fall_o(fall), .edge_o(any_edge)
    );

    ir_cell_timer #(.NOM_TICKS(NOM_TICKS), .W(TIMER_W)) i_timer (
        .clk(clk), .rst(rst), .tick_i(tick_en),
        .load_nom_i(load_nom), .capture_i(capture),
        .at_sample_o(at_sample), .at_timeout_o(at_timeout)
    );

    ir_frame_ctrl i_ctrl (
        .clk(clk), .rst(rst), .level_i(level), .fall_i(fall), .edge_i(any_edge),
        .at_sample_i(at_sample), .at_timeout_i(at_timeout),
        .load_nom_o(load_nom), .capture_o(capture),
        .done_o(done), .abort_o(abort), .shreg_o(shreg)
    );

    assign decoded = unpack_frame(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q  <= '0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
            new_q    <= 1'b0;
            stored_q <= 1'b0;
            seen_q   <= 1'b0;
        end else begin
            valid_q <= done;
            err_q   <= abort;
            if (done) begin
                frame_q  <= decoded;
                new_q    <= !seen_q || (decoded.tog != stored_q);
                stored_q <= decoded.tog;
                seen_q   <= 1'b1;
            end
        end
    end

    assign cmd_o    = frame_q.cmd;
    assign addr_o   = frame_q.addr;
    assign toggle_o = frame_q.tog;
    assign valid_o  = valid_q;
    assign is_new_o = new_q;
    assign err_o    = err_q;

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_fields_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(cmd_o) && $stable(addr_o) && $stable(toggle_o) && $stable(is_new_o)));

    assert_err_excludes_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !(err_o && valid_o));

    assert_toggle_memory_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (stored_q == toggle_o));

endmodule

// File: tb/test_ir_biphase_rx.sv
module test_ir_biphase_rx;
    localparam int NOM = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       ir_line = 1'b0;
    logic [6:0] cmd_o;
    logic [4:0] addr_o;
    logic       toggle_o, valid_o, is_new_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    int n_valid = 0;
    int n_err = 0;
    logic [6:0] cap_cmd = '0;
    logic [4:0] cap_addr = '0;
    logic       cap_tog = 1'b0;
    logic       cap_new = 1'b0;

    always #4 clk = ~clk;

    ir_biphase_rx #(.NOM_TICKS(NOM), .SYNC_STAGES(2)) i_ir_biphase_rx (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ir_line(ir_line),
        .cmd_o(cmd_o), .addr_o(addr_o), .toggle_o(toggle_o),
        .valid_o(valid_o), .is_new_o(is_new_o), .err_o(err_o)
    );

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                n_valid  = n_valid + 1;
                cap_cmd  = cmd_o;
                cap_addr = addr_o;
                cap_tog  = toggle_o;
                cap_new  = is_new_o;
            end
            if (err_o) n_err = n_err + 1;
        end
    end

    typedef struct packed {
        logic       tog;
        logic [4:0] addr;
        logic [6:0] cmd;
        logic [7:0] per;
        logic       exp_new;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 5'h05, 7'h35, 8'd40, 1'b1},
        '{1'b0, 5'h05, 7'h35, 8'd40, 1'b0},
        '{1'b1, 5'h1F, 7'h7F, 8'd36, 1'b1},
        '{1'b1, 5'h1F, 7'h7F, 8'd44, 1'b0},
        '{1'b0, 5'h00, 7'h00, 8'd44, 1'b1},
        '{1'b1, 5'h15, 7'h2A, 8'd40, 1'b1},
        '{1'b0, 5'h0A, 7'h55, 8'd36, 1'b1},
        '{1'b0, 5'h11, 7'h41, 8'd48, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic [13:0] frame_bits(input logic tog, input logic [4:0] a, input logic [6:0] c);
        return {1'b1, ~c[6], tog, a, c[5:0]};
    endfunction

    // drive ncells cells; leave_low keeps the line low afterwards
    task automatic send(input logic [13:0] bits, input int per, input int ncells, input logic leave_low);
        for (int i = 0; i < ncells; i++) begin
            @(negedge clk);
            ir_line = bits[13-i];
            repeat (per / 2) @(negedge clk);
            ir_line = ~bits[13-i];
            repeat (per / 2 - 1) @(negedge clk);
        end
        @(negedge clk);
        ir_line = leave_low ? 1'b0 : 1'b1;
    endtask

    task automatic full_frame(input logic tog, input logic [4:0] a, input logic [6:0] c,
                              input int per, input logic exp_new, input string tag);
        int v0, e0;
        v0 = n_valid;
        e0 = n_err;
        send(frame_bits(tog, a, c), per, 14, 1'b0);
        wait_cyc(3 * per);
        check(n_valid == v0 + 1, {tag, " R8 one valid per frame"}, n_valid - v0, 1);
        check(n_err == e0, {tag, " R8 no error after frame"}, n_err - e0, 0);
        check(cap_cmd == c, {tag, " R5 command"}, cap_cmd, c);
        check(cap_addr == a, {tag, " R5 address"}, cap_addr, a);
        check(cap_tog == tog, {tag, " R5 toggle"}, cap_tog, tog);
        check(cap_new == exp_new, {tag, " R7 new flag"}, cap_new, exp_new);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int v0, e0;
        logic [6:0] hold_cmd;
        logic [4:0] hold_addr;

        // R9: reset state
        repeat (5) @(negedge clk);
        #1;
        check(valid_o == 1'b0 && err_o == 1'b0, "R9 pulses low in reset", {valid_o, err_o}, 0);
        check(cmd_o == '0 && addr_o == '0 && toggle_o == 1'b0 && is_new_o == 1'b0,
              "R9 fields zero in reset", {cmd_o, addr_o, toggle_o, is_new_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(2);
        check(cmd_o == '0 && valid_o == 1'b0, "R9 fields zero after reset", cmd_o, 0);

        // R1: line low out of reset starts nothing, rising starts nothing
        wait_cyc(100);
        ir_line = 1'b1;
        wait_cyc(200);
        check(n_valid == 0 && n_err == 0, "R1 low line then rise starts nothing",
              n_valid + n_err, 0);

        // R2 R3 R5 R7 R8: vector table with period variation
        for (int k = 0; k < NVEC; k++) begin
            full_frame(VEC[k].tog, VEC[k].addr, VEC[k].cmd, int'(VEC[k].per),
                       VEC[k].exp_new, "R3 vector");
        end

        // R4: truncated frame, line left high
        hold_cmd  = cmd_o;
        hold_addr = addr_o;
        v0 = n_valid;
        e0 = n_err;
        send(frame_bits(1'b1, 5'h0C, 7'h33), NOM, 6, 1'b0);
        wait_cyc(3 * NOM);
        check(n_err == e0 + 1, "R4 truncated frame error pulse", n_err - e0, 1);
        check(n_valid == v0, "R4 truncated frame no valid", n_valid - v0, 0);
        check(cmd_o == hold_cmd && addr_o == hold_addr, "R4 fields unchanged",
              {cmd_o, addr_o}, {hold_cmd, hold_addr});

        // R4 R1: truncated with line held low, then rearm on high
        e0 = n_err;
        send(frame_bits(1'b1, 5'h0C, 7'h33), NOM, 4, 1'b1);
        wait_cyc(5 * NOM);
        check(n_err == e0 + 1, "R4 low-held truncation error", n_err - e0, 1);
        ir_line = 1'b1;
        wait_cyc(2 * NOM);
        check(n_err == e0 + 1 && n_valid == v0, "R1 rise after abort starts nothing",
              n_err - e0, 1);
        full_frame(1'b1, 5'h0C, 7'h33, NOM, 1'b1, "R1 rearmed frame");

        // R2 R4 boundary: first cell too long for nominal timeout
        v0 = n_valid;
        e0 = n_err;
        send(frame_bits(1'b0, 5'h03, 7'h0F), 52, 14, 1'b0);
        wait_cyc(3 * NOM);
        check(n_err >= e0 + 1, "R2 first cell 52 ticks dropped", n_err - e0, 1);
        check(n_valid == v0, "R2 first cell 52 ticks no valid", n_valid - v0, 0);
        wait_cyc(6 * NOM);

        // R6: fields stable long after a valid pulse
        hold_cmd = cmd_o;
        wait_cyc(50);
        check(cmd_o == hold_cmd && valid_o == 1'b0, "R6 outputs hold between frames",
              cmd_o, hold_cmd);

        // R7: same toggle as last decoded frame is a repeat
        full_frame(1'b1, 5'h02, 7'h01, NOM, 1'b0, "R7 repeat after abort");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule